// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits between a CPU-side register bus and a device-side configuration model on a host bridge. It exposes two windows, each 4 KiB: an index window that holds one 32-bit configuration pointer, and a data window. Every access to the data window is turned into a single configuration read or write toward the device side. The outgoing address is built from the stored pointer and the low bits of the data-window address.

The pointer has two encodings, chosen by its top bit. With bit 31 set it is already a standard type-1 address and is passed on almost unchanged. With bit 31 clear, bits 31..11 act as a one-hot slot select, and the lowest set bit among them becomes the device number. A pointer whose slot field is empty has no target: the access finishes locally and nothing is sent to the device side.

The block also merges four interrupt pins from each device slot onto four shared level lines, rotating each device's pins by its device number. On the CPU side, a request is offered with `cpu_valid` and must hold all of its fields stable until `cpu_ready` pulses for one cycle. The requester drops `cpu_valid` before the next edge. On the device side, `dev_req_valid` is a one-cycle strobe, and the device may take any number of cycles before it pulses `dev_rsp_valid`. The CPU side stays stalled for that whole time.

Top module: `pcfg_bridge`

## Requirements
- R1: After reset the pointer is zero, `int_out` is 0000, and `cpu_ready` and `dev_req_valid` are both low.
- R2: In the index window (`cpu_sel_data`=0), address bits 11..2 equal to zero select the pointer. A read there returns the whole pointer, and a write updates only the byte lanes enabled per R6. At any other offset a read returns zero and a write changes nothing.
- R3: With pointer bit 31 set, the configuration address is the pointer OR'd with data-window address bits 1..0.
- R4: With pointer bit 31 clear, the configuration address is built as follows. Bits 15..11 hold the slot, which is the position of the lowest set pointer bit in 31..11. Bits 10..8 are pointer bits 10..8 (the function). Bits 7..3 are pointer bits 7..3. Bits 2..0 are data-window address bits 2..0. All other bits are zero.
- R5: With pointer bit 31 clear and bits 31..11 all zero, no device request is issued. A read returns FFFFFFFF, a write is dropped, and `cpu_ready` still pulses.
- R6: `cpu_size` selects the byte enables from address bits 1..0. The value 00 (byte) gives 0001 shifted left by the address. The value 01 (halfword) gives 0011, or 1100 when address bit 1 is set. The values 10 and 11 (word) give 1111. Write data is already lane-aligned and passes through unchanged.
- R7: A targeted data-window access raises `dev_req_valid` for exactly one cycle. `cpu_ready` pulses in the cycle after `dev_rsp_valid` is seen, never earlier, and for a read `cpu_rdata` then carries `dev_rsp_rdata`.
- R8: Pin n of device d (bit 4d+n of `dev_int_pins`) drives line (n+d) mod 4 of `int_out`. Each line is the registered OR of its pins, one cycle behind its inputs.
- R9: `cpu_ready` is a one-cycle pulse. Accesses that finish locally raise it in the cycle after `cpu_valid` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request offered |
| cpu_ready | output | 1 | CPU request complete (one-cycle pulse) |
| cpu_sel_data | input | 1 | 0 = index window, 1 = data window |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Offset inside the selected window |
| cpu_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| cpu_wdata | input | 32 | Lane-aligned write data |
| cpu_rdata | output | 32 | Read data, valid while cpu_ready is high |
| dev_req_valid | output | 1 | Configuration request strobe |
| dev_req_write | output | 1 | Request is a write |
| dev_req_addr | output | 32 | Translated configuration address |
| dev_req_be | output | 4 | Byte enables |
| dev_req_wdata | output | 32 | Write data |
| dev_rsp_valid | input | 1 | Device response strobe |
| dev_rsp_rdata | input | 32 | Device read data |
| dev_int_pins | input | NUM_DEV*4 | Interrupt pins, four per device |
| int_out | output | 4 | Shared level interrupt lines |

## Verification
The assertions check the following on every cycle:
- request and ready strobes last a single cycle;
- `cpu_ready` never shows while a device request is still outstanding;
- byte enables always have a legal shape;
- a decoded-format address never carries a slot below 11 or a nonzero bus field;
- quiet interrupt pins lead to quiet lines.

Only the directed scenarios can show that the addresses are exact. These cover each pointer format, lowest-bit selection when several slot bits are set, and the no-target reply. The scenarios also cover pointer byte merging, the exact response latency for several device delays, and which line each device pin lands on.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int CFG_W    = 32;
  localparam int SLOT_LSB = 11;
  localparam int LANES    = CFG_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } pcfg_state_t;

  // Lane mask for an access of the given size at the given low address.
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] sz,
                                                 input logic [1:0] lo);
    logic [LANES-1:0] m;
    case (sz)
      2'b00:   m = 4'b0001 << lo;
      2'b01:   m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = 4'b1111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pcfg_xlate.sv
module pcfg_xlate
  import pcfg_pkg::*;
(
  input  logic [CFG_W-1:0] ptr,
  input  logic [2:0]       acc_lo,
  output logic [CFG_W-1:0] cfg_addr,
  output logic             has_target
);

  logic       slot_found;
  logic [4:0] slot_num;

  // Scan from the top down so the lowest set bit is the last one kept.
  always_comb begin
    slot_found = 1'b0;
    slot_num   = '0;
    for (int i = CFG_W - 1; i >= SLOT_LSB; i--) begin
      if (ptr[i]) begin
        slot_found = 1'b1;
        slot_num   = 5'(i);
      end
    end
  end

  always_comb begin
    if (ptr[CFG_W-1]) begin
      cfg_addr   = ptr | {{(CFG_W-2){1'b0}}, acc_lo[1:0]};
      has_target = 1'b1;
    end else begin
      cfg_addr   = {16'h0000, slot_num, ptr[10:8], ptr[7:3], acc_lo};
      has_target = slot_found;
    end
  end

endmodule

// File: rtl/pcfg_irq_swizzle.sv
module pcfg_irq_swizzle #(
  parameter int NUM_DEV   = 32,
  parameter int NUM_LINES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEV*NUM_LINES-1:0] pins,
  output logic [NUM_LINES-1:0]     lines
);

  logic [NUM_LINES-1:0] merged;

  always_comb begin
    merged = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        merged[(n + d) % NUM_LINES] = merged[(n + d) % NUM_LINES]
                                    | pins[d*NUM_LINES + n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lines <= '0;
    else        lines <= merged;
  end

endmodule

// File: rtl/pcfg_bridge.sv
module pcfg_bridge
  import pcfg_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int WIN_AW  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_valid,
  output logic                   cpu_ready,
  input  logic                   cpu_sel_data,
  input  logic                   cpu_write,
  input  logic [WIN_AW-1:0]      cpu_addr,
  input  logic [1:0]             cpu_size,
  input  logic [31:0]            cpu_wdata,
  output logic [31:0]            cpu_rdata,
  output logic                   dev_req_valid,
  output logic                   dev_req_write,
  output logic [31:0]            dev_req_addr,
  output logic [3:0]             dev_req_be,
  output logic [31:0]            dev_req_wdata,
  input  logic                   dev_rsp_valid,
  input  logic [31:0]            dev_rsp_rdata,
  input  logic [NUM_DEV*4-1:0]   dev_int_pins,
  output logic [3:0]             int_out
);

  localparam int NUM_LINES = 4;

  pcfg_state_t      state;
  logic [CFG_W-1:0] ptr_q;
  logic [CFG_W-1:0] xl_addr;
  logic             xl_hit;
  logic             ptr_sel;
  logic [LANES-1:0] acc_be;

  assign ptr_sel   = (cpu_addr[WIN_AW-1:2] == '0);
  assign acc_be    = lane_mask(cpu_size, cpu_addr[1:0]);
  assign cpu_ready = (state == ST_DONE);

  pcfg_xlate u_xlate (
    .ptr        (ptr_q),
    .acc_lo     (cpu_addr[2:0]),
    .cfg_addr   (xl_addr),
    .has_target (xl_hit)
  );

  pcfg_irq_swizzle #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .pins  (dev_int_pins),
    .lines (int_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      ptr_q         <= '0;
      cpu_rdata     <= '0;
      dev_req_valid <= 1'b0;
      dev_req_write <= 1'b0;
      dev_req_addr  <= '0;
      dev_req_be    <= '0;
      dev_req_wdata <= '0;
    end else begin
      dev_req_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_valid) begin
            if (!cpu_sel_data) begin
              // Index window: one pointer word at offset zero.
              if (cpu_write) begin
                if (ptr_sel) begin
                  for (int b = 0; b < LANES; b++) begin
                    if (acc_be[b]) ptr_q[8*b +: 8] <= cpu_wdata[8*b +: 8];
                  end
                end
              end else begin
                cpu_rdata <= ptr_sel ? ptr_q : '0;
              end
              state <= ST_DONE;
            end else if (!xl_hit) begin
              // No slot selected: answer locally.
              if (!cpu_write) cpu_rdata <= '1;
              state <= ST_DONE;
            end else begin
              dev_req_valid <= 1'b1;
              dev_req_write <= cpu_write;
              dev_req_addr  <= xl_addr;
              dev_req_be    <= acc_be;
              dev_req_wdata <= cpu_wdata;
              state         <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dev_rsp_valid) begin
            if (!dev_req_write) cpu_rdata <= dev_rsp_rdata;
            state <= ST_DONE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcfg_bridge_chk.sv
module pcfg_bridge_chk #(
  parameter int NUM_DEV = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_ready,
  input logic                 dev_req_valid,
  input logic [31:0]          dev_req_addr,
  input logic [3:0]           dev_req_be,
  input logic                 dev_rsp_valid,
  input logic [NUM_DEV*4-1:0] dev_int_pins,
  input logic [3:0]           int_out
);

  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)             pending <= 1'b0;
    else if (dev_rsp_valid) pending <= 1'b0;
    else if (dev_req_valid) pending <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (int_out == 4'b0000 && !cpu_ready && !dev_req_valid));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid |=> !dev_req_valid);

  p_ready_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !pending && !dev_req_valid);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid |-> ($countones(dev_req_be) == 1 ||
                       $countones(dev_req_be) == 2 ||
                       $countones(dev_req_be) == 4));

  p_decoded_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_valid && !dev_req_addr[31]) |->
      (dev_req_addr[15:11] >= 5'd11 && dev_req_addr[30:16] == '0));

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_int_pins == '0) |=> (int_out == 4'b0000));

endmodule

bind pcfg_bridge pcfg_bridge_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_ready     (cpu_ready),
  .dev_req_valid (dev_req_valid),
  .dev_req_addr  (dev_req_addr),
  .dev_req_be    (dev_req_be),
  .dev_rsp_valid (dev_rsp_valid),
  .dev_int_pins  (dev_int_pins),
  .int_out       (int_out)
);

// File: tb/pcfg_bridge_tb.sv
module pcfg_bridge_tb;

  localparam int NDEV = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_valid = 1'b0;
  logic              cpu_ready;
  logic              cpu_sel_data = 1'b0;
  logic              cpu_write = 1'b0;
  logic [11:0]       cpu_addr = '0;
  logic [1:0]        cpu_size = '0;
  logic [31:0]       cpu_wdata = '0;
  logic [31:0]       cpu_rdata;
  logic              dev_req_valid;
  logic              dev_req_write;
  logic [31:0]       dev_req_addr;
  logic [3:0]        dev_req_be;
  logic [31:0]       dev_req_wdata;
  logic              dev_rsp_valid = 1'b0;
  logic [31:0]       dev_rsp_rdata = '0;
  logic [NDEV*4-1:0] dev_int_pins = '0;
  logic [3:0]        int_out;

  int total = 0;
  int bad   = 0;
  logic [31:0] rsp_word = 32'h1234_5678;

  // Results of the last transfer.
  logic [31:0] x_rd;
  logic        x_req;
  logic [31:0] x_addr;
  logic [3:0]  x_be;
  logic        x_wr;
  logic [31:0] x_wd;
  int          x_lat;

  always #10 clk = ~clk;

  pcfg_bridge #(.NUM_DEV(NDEV)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_sel_data(cpu_sel_data), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dev_req_valid(dev_req_valid), .dev_req_write(dev_req_write),
    .dev_req_addr(dev_req_addr), .dev_req_be(dev_req_be),
    .dev_req_wdata(dev_req_wdata),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_rdata(dev_rsp_rdata),
    .dev_int_pins(dev_int_pins), .int_out(int_out)
  );

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One CPU access; plays the device side with the given response delay.
  task automatic xfer(input logic sel, input logic wr, input logic [11:0] a,
                      input logic [1:0] sz, input logic [31:0] wd,
                      input int dly);
    int  cnt;
    bit  done;
    cnt = -1;
    done = 0;
    x_req = 0; x_lat = 0; x_rd = 'x;
    @(negedge clk);
    cpu_sel_data = sel; cpu_write = wr; cpu_addr = a;
    cpu_size = sz; cpu_wdata = wd; cpu_valid = 1'b1;
    for (int t = 0; t < 500 && !done; t++) begin
      @(negedge clk);
      x_lat++;
      dev_rsp_valid = 1'b0;
      if (dev_req_valid) begin
        x_req = 1; x_addr = dev_req_addr; x_be = dev_req_be;
        x_wr = dev_req_write; x_wd = dev_req_wdata; cnt = dly;
      end
      if (cnt == 0) begin
        dev_rsp_valid = 1'b1; dev_rsp_rdata = rsp_word; cnt = -1;
      end else if (cnt > 0) begin
        cnt--;
      end
      if (cpu_ready) begin
        x_rd = cpu_rdata; cpu_valid = 1'b0; done = 1;
      end
    end
    if (!done) chk("R9 transfer completion", 32'd0, 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 int_out after reset", {28'h0, int_out}, 32'h0);
    chk("R1 cpu_ready after reset", {31'h0, cpu_ready}, 32'h0);
    chk("R1 dev_req_valid after reset", {31'h0, dev_req_valid}, 32'h0);
    xfer(1'b0, 1'b0, 12'h000, 2'b10, 32'h0, 0);
    chk("R1 pointer after reset", x_rd, 32'h0);
  endtask

  task automatic t_index_rw;
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h1122_3344, 0);
    chk("R9 index write latency", x_lat, 1);
    xfer(1'b0, 1'b1, 12'h002, 2'b00, 32'h00AB_0000, 0);
    xfer(1'b0, 1'b0, 12'h000, 2'b10, 32'h0, 0);
    chk("R2 byte merge into pointer", x_rd, 32'h11AB_3344);
    xfer(1'b0, 1'b1, 12'h004, 2'b10, 32'hFFFF_FFFF, 0);
    xfer(1'b0, 1'b0, 12'h004, 2'b10, 32'h0, 0);
    chk("R2 other offset reads zero", x_rd, 32'h0);
    xfer(1'b0, 1'b0, 12'h000, 2'b10, 32'h0, 0);
    chk("R2 other offset write ignored", x_rd, 32'h11AB_3344);
  endtask

  task automatic t_type1;
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h8001_2344, 0);
    rsp_word = 32'hCAFE_0001;
    xfer(1'b1, 1'b0, 12'h003, 2'b00, 32'h0, 0);
    chk("R3 type-1 address", x_addr, 32'h8001_2347);
    chk("R6 byte lane 3", {28'h0, x_be}, 32'h8);
    chk("R7 read data returned", x_rd, 32'hCAFE_0001);
    chk("R7 latency delay 0", x_lat, 2);
  endtask

  task automatic t_decode;
    // bit 11 set, function 2, register bits 0x14
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h0000_0A14, 0);
    xfer(1'b1, 1'b1, 12'h006, 2'b01, 32'hBEEF_0000, 1);
    chk("R4 decoded address slot 11", x_addr, 32'h0000_5A16);
    chk("R6 upper halfword lanes", {28'h0, x_be}, 32'hC);
    chk("R6 write data passthrough", x_wd, 32'hBEEF_0000);
    chk("R7 write flag", {31'h0, x_wr}, 32'h1);
    // bits 20 and 21 set: lowest wins
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h0030_0000, 0);
    xfer(1'b1, 1'b0, 12'h000, 2'b10, 32'h0, 0);
    chk("R4 lowest set bit slot 20", x_addr, 32'h0000_A000);
    chk("R6 word lanes", {28'h0, x_be}, 32'hF);
  endtask

  task automatic t_no_target;
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h0000_07FC, 0);
    xfer(1'b1, 1'b0, 12'h001, 2'b00, 32'h0, 0);
    chk("R5 no target read value", x_rd, 32'hFFFF_FFFF);
    chk("R5 no device request on read", {31'h0, x_req}, 32'h0);
    chk("R9 no target latency", x_lat, 1);
    xfer(1'b1, 1'b1, 12'h000, 2'b10, 32'h5555_5555, 0);
    chk("R5 no device request on write", {31'h0, x_req}, 32'h0);
  endtask

  task automatic t_latency;
    xfer(1'b0, 1'b1, 12'h000, 2'b10, 32'h0000_1000, 0);
    for (int d = 1; d <= 5; d += 2) begin
      rsp_word = 32'hD00D_0000 + d;
      xfer(1'b1, 1'b0, 12'h001, 2'b00, 32'h0, d);
      chk("R7 ready waits for response", x_lat, d + 2);
      chk("R7 delayed read data", x_rd, 32'hD00D_0000 + d);
      chk("R6 byte lane 1", {28'h0, x_be}, 32'h2);
    end
  endtask

  task automatic t_irq;
    @(negedge clk);
    dev_int_pins = '0;
    dev_int_pins[1*4 + 0] = 1'b1;        // dev 1 pin 0 -> line 1
    @(negedge clk);
    chk("R8 dev1 pin0 to line1", {28'h0, int_out}, 32'h2);
    dev_int_pins = '0;
    dev_int_pins[4*4 + 3] = 1'b1;        // dev 4 pin 3 -> line 3
    dev_int_pins[2*4 + 0] = 1'b1;        // dev 2 pin 0 -> line 2
    @(negedge clk);
    chk("R8 two devices two lines", {28'h0, int_out}, 32'hC);
    dev_int_pins = '0;
    dev_int_pins[31*4 + 2] = 1'b1;       // dev 31 pin 2 -> line 1
    @(negedge clk);
    chk("R8 dev31 pin2 to line1", {28'h0, int_out}, 32'h2);
    dev_int_pins = '0;
    @(negedge clk);
    chk("R8 lines drop", {28'h0, int_out}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_rw();
    t_type1();
    t_decode();
    t_no_target();
    t_latency();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule